// File: doc/BRIEF.md
# Single-Threaded Burst Master Port

This block sits between a single-threaded CPU core and a request/data/response socket. The core hands it one read or write burst at a time: a start address, a length code, an address order and a request byte-enable mask. The port turns this into exactly one request phase on the socket. That request carries the command, the word-aligned start address, the exact beat count and the burst order. For writes, the data beats travel on a separate valid/last/accept handshake that runs independently of the request. For reads, the response beats are passed straight back to the core together with their error status and a last-beat flag.

Writes are posted. A write is finished when its request has been accepted and its last data beat has been taken. No response is expected. Failures of posted writes arrive later on a sideband error input, and the port keeps that error in a sticky flag that the core clears with a pulse. The port cannot hold off response beats. Every non-null response during a read is forwarded in the cycle it appears. For every beat the port also presents the beat's address, computed in either wrap order or XOR (critical-word-first) order, so the core knows which word is moving.

Only one transaction is in flight at a time. A new request is taken only after the previous one has finished.

Top module: `burst_master_port`

## Requirements
- R1: After a synchronous active-low reset, `m_cmd` is idle, `m_dvalid` and `cpu_rdata_valid` are 0, `cpu_req_ready` is 1 and `cpu_wr_err` is 0.
- R2: A burst drives exactly one request phase. `m_cmd` is 2'b01 for a posted write and 2'b10 for a read. It returns to 2'b00 (idle) in the cycle after `s_cmd_accept` and stays idle for the rest of the burst. While the request waits, `m_cmd`, `m_addr`, `m_byteen`, `m_blen` and `m_bseq` are held stable. `m_addr` is the request address with its two lowest bits cleared. `m_bseq` is 0 for wrap order and 1 for XOR order.
- R3: The length code `cpu_req_len` selects 1, 2, 4 or 8 beats for codes 0, 1, 2 and 3. `m_blen` carries this beat count as a number.
- R4: During a write burst, `m_dvalid` follows `cpu_wdata_valid` and `cpu_wdata_ready` follows `s_data_accept`, with `m_data` and `m_dbyteen` taken from the core. Exactly as many beats as the beat count are transferred. `m_dlast` is high on the final beat only.
- R5: A write completes without any response phase. `cpu_req_ready` returns in the cycle after both the request acceptance and the last data acceptance have happened, in either order. Data may be taken before the request is accepted.
- R6: During a read, every cycle with `s_resp` other than 2'b00 (null) is forwarded in the same cycle as a valid beat carrying `s_data`. `cpu_rdata_err` is high exactly when `s_resp` is 2'b11 (error). A beat flagged as an error does not cut the burst short.
- R7: A read ends on the response beat with `s_resp_last` high. `cpu_rdata_last` marks that beat, and `cpu_req_ready` returns in the next cycle.
- R8: Only one transaction is outstanding. `cpu_req_ready` is low from the cycle after a request is taken until the transaction completes.
- R9: In wrap order (`cpu_req_seq` = 0), beat i of an N-beat burst has word index (w + i) mod N inside the N-word-aligned block that holds the start word w. `cpu_beat_addr` presents that address with each write and read beat.
- R10: In XOR order (`cpu_req_seq` = 1), beat i has word index w XOR i inside the same N-word-aligned block.
- R11: A high `s_error` sets `cpu_wr_err` from the next cycle on. The flag stays set until `cpu_err_clear` is pulsed, which clears it in the next cycle. A set and a clear in the same cycle leave the flag set.
- R12: Response inputs are ignored outside the response wait of a read, including while a read request is still waiting for acceptance. In those cycles `cpu_rdata_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Core presents a burst request |
| cpu_req_ready | output | 1 | Port is free and takes the request |
| cpu_req_write | input | 1 | 1 = posted write, 0 = read |
| cpu_req_addr | input | AW | Start byte address |
| cpu_req_len | input | 2 | Length code: beats = 2^code |
| cpu_req_seq | input | 1 | 0 = wrap order, 1 = XOR order |
| cpu_req_be | input | BEW | Request byte enables |
| cpu_wdata_valid | input | 1 | Core offers a write beat |
| cpu_wdata_ready | output | 1 | Write beat taken this cycle |
| cpu_wdata | input | DW | Write beat data |
| cpu_wbe | input | BEW | Write beat byte enables |
| cpu_beat_addr | output | AW | Address of the current beat |
| cpu_rdata_valid | output | 1 | Read beat delivered |
| cpu_rdata | output | DW | Read beat data |
| cpu_rdata_err | output | 1 | Read beat carried an error |
| cpu_rdata_last | output | 1 | Final read beat |
| cpu_err_clear | input | 1 | Pulse that clears the write error flag |
| cpu_wr_err | output | 1 | Sticky posted-write error |
| m_cmd | output | 2 | Command: 00 idle, 01 posted write, 10 read |
| m_addr | output | AW | Burst start address |
| m_byteen | output | BEW | Request byte enables |
| m_blen | output | 4 | Exact beat count |
| m_bseq | output | 1 | Burst order: 0 wrap, 1 XOR |
| s_cmd_accept | input | 1 | Slave accepts the request |
| m_dvalid | output | 1 | Write data valid |
| m_data | output | DW | Write data |
| m_dbyteen | output | BEW | Write data byte enables |
| m_dlast | output | 1 | Last write beat |
| s_data_accept | input | 1 | Slave accepts the write beat |
| s_resp | input | 2 | Response: 00 null, 01 data valid, 11 error |
| s_data | input | DW | Read data |
| s_resp_last | input | 1 | Last response beat |
| s_error | input | 1 | Posted-write error sideband |

## Verification
A broken beat counter shows up within the same burst as a misplaced `m_dlast` or `cpu_rdata_last`, or as a wrong `cpu_beat_addr` on the first beat after the fault. A state register stuck busy or released too early shows up as a wrong `cpu_req_ready` in the cycle right after completion, or as a second request phase on `m_cmd`. Faults in the error flag show up one cycle after an `s_error` or `cpu_err_clear` pulse. The stimulus mixes random slave stalls, both orders of request and data acceptance, null gaps, error beats and ignored response noise, so that every beat position and both address orders are exercised.

// File: rtl/bmp_pkg.sv
// Shared encodings for the burst master port.
// Assumes a two-bit command and response field on the socket side.
package bmp_pkg;
    localparam logic [1:0] CMD_IDLE   = 2'b00;
    localparam logic [1:0] CMD_WRPOST = 2'b01;
    localparam logic [1:0] CMD_READ   = 2'b10;

    localparam logic [1:0] RSP_NULL = 2'b00;
    localparam logic [1:0] RSP_DVA  = 2'b01;
    localparam logic [1:0] RSP_ERR  = 2'b11;

    localparam logic ORD_WRAP = 1'b0;
    localparam logic ORD_XOR  = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RDREQ,
        ST_RDRSP
    } bmp_state_e;
endpackage

// File: rtl/bmp_beat_seq.sv
// Beat address sequencer: holds the start address, length and order of the
// current burst and produces each beat's address plus a last-beat flag.
// Assumes the loaded address is already word aligned and 2^len <= 2^IDXW.
module bmp_beat_seq #(
    parameter int AW   = 32,
    parameter int IDXW = 3,
    parameter int LSB  = 2,
    parameter int LCW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [AW-1:0]  ld_addr,
    input  logic [LCW-1:0] ld_len,
    input  logic           ld_ord,
    input  logic           adv,
    output logic [AW-1:0]  beat_addr,
    output logic           beat_last
);
    import bmp_pkg::*;

    logic [AW-1:0]   base_q;
    logic [LCW-1:0]  len_q;
    logic            ord_q;
    logic [IDXW-1:0] idx_q;
    logic [IDXW:0]   span;
    logic [IDXW-1:0] mask;
    logic [IDXW-1:0] word;
    logic [IDXW-1:0] pick;

    // Capture burst parameters on load and step the beat index on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            ord_q  <= ORD_WRAP;
            idx_q  <= '0;
        end else if (load) begin
            base_q <= ld_addr;
            len_q  <= ld_len;
            ord_q  <= ld_ord;
            idx_q  <= '0;
        end else if (adv) begin
            idx_q <= beat_last ? '0 : idx_q + 1'b1;
        end
    end

    // Form the beat address by replacing the in-block word bits.
    always_comb begin
        span  = {{IDXW{1'b0}}, 1'b1} << len_q;
        mask  = span[IDXW-1:0] - {{(IDXW-1){1'b0}}, 1'b1};
        word  = base_q[LSB +: IDXW];
        pick  = (ord_q == ORD_XOR) ? (word ^ idx_q) : (word + idx_q);
        beat_addr = base_q;
        beat_addr[LSB +: IDXW] = (word & ~mask) | (pick & mask);
        beat_last = (idx_q == mask);
    end

    // After the final beat the sequence must point at the start word again.
    assert_seq_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && beat_last && !load) |=> (beat_addr == $past(base_q)));
endmodule

// File: rtl/bmp_wr_lane.sv
// Write data lane: joins the core's write beats to the socket's data
// handshake while a write burst still owes data. No storage; it assumes
// the core holds each beat until it sees ready.
module bmp_wr_lane #(
    parameter int DW  = 32,
    parameter int BEW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  logic           last_beat,
    input  logic           cpu_wdata_valid,
    input  logic [DW-1:0]  cpu_wdata,
    input  logic [BEW-1:0] cpu_wbe,
    input  logic           s_data_accept,
    output logic           cpu_wdata_ready,
    output logic           m_dvalid,
    output logic [DW-1:0]  m_data,
    output logic [BEW-1:0] m_dbyteen,
    output logic           m_dlast,
    output logic           beat_take,
    output logic           last_take
);
    // Drive the socket data channel only while the burst owes beats.
    always_comb begin
        m_dvalid        = active && cpu_wdata_valid;
        m_data          = active ? cpu_wdata : '0;
        m_dbyteen       = active ? cpu_wbe : '0;
        m_dlast         = m_dvalid && last_beat;
        cpu_wdata_ready = active && s_data_accept;
        beat_take       = m_dvalid && s_data_accept;
        last_take       = beat_take && last_beat;
    end

    // Once the final beat is taken no further data may be offered.
    assert_last_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_dvalid && m_dlast && s_data_accept) |=> !m_dvalid);
endmodule

// File: rtl/bmp_err_sticky.sv
// Sticky posted-write error flag: set by the sideband error input,
// cleared by a pulse from the core; a set in the same cycle wins.
module bmp_err_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the error until cleared, giving priority to a new error.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assert_err_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    assert_err_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    assert_err_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/burst_master_port.sv
// Single-threaded burst master port. Takes one CPU burst at a time and
// issues a single request phase with an exact beat count; write data runs
// on its own handshake and is posted; read responses are forwarded in the
// cycle they appear, since the port cannot stall them. Assumes the slave
// raises s_resp_last on the final read beat.
module burst_master_port #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int MAX_BEATS = 8,
    localparam int BEW  = DW / 8,
    localparam int LSB  = $clog2(BEW),
    localparam int IDXW = $clog2(MAX_BEATS),
    localparam int BLW  = IDXW + 1,
    localparam int LCW  = $clog2(IDXW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_req_valid,
    output logic           cpu_req_ready,
    input  logic           cpu_req_write,
    input  logic [AW-1:0]  cpu_req_addr,
    input  logic [LCW-1:0] cpu_req_len,
    input  logic           cpu_req_seq,
    input  logic [BEW-1:0] cpu_req_be,
    input  logic           cpu_wdata_valid,
    output logic           cpu_wdata_ready,
    input  logic [DW-1:0]  cpu_wdata,
    input  logic [BEW-1:0] cpu_wbe,
    output logic [AW-1:0]  cpu_beat_addr,
    output logic           cpu_rdata_valid,
    output logic [DW-1:0]  cpu_rdata,
    output logic           cpu_rdata_err,
    output logic           cpu_rdata_last,
    input  logic           cpu_err_clear,
    output logic           cpu_wr_err,
    output logic [1:0]     m_cmd,
    output logic [AW-1:0]  m_addr,
    output logic [BEW-1:0] m_byteen,
    output logic [BLW-1:0] m_blen,
    output logic           m_bseq,
    input  logic           s_cmd_accept,
    output logic           m_dvalid,
    output logic [DW-1:0]  m_data,
    output logic [BEW-1:0] m_dbyteen,
    output logic           m_dlast,
    input  logic           s_data_accept,
    input  logic [1:0]     s_resp,
    input  logic [DW-1:0]  s_data,
    input  logic           s_resp_last,
    input  logic           s_error
);
    import bmp_pkg::*;

    bmp_state_e     state_q, state_d;
    logic           req_pend_q, req_pend_d;
    logic           dat_done_q, dat_done_d;
    logic [AW-1:0]  addr_q;
    logic [LCW-1:0] len_q;
    logic           ord_q;
    logic [BEW-1:0] be_q;
    logic [AW-1:0]  start_addr;
    logic           req_fire;
    logic           wr_active;
    logic           rsp_vld;
    logic           beat_last;
    logic           wr_beat;
    logic           wr_last;

    assign cpu_req_ready = (state_q == ST_IDLE);
    assign req_fire      = cpu_req_valid && cpu_req_ready;
    assign start_addr    = {cpu_req_addr[AW-1:LSB], {LSB{1'b0}}};
    assign wr_active     = (state_q == ST_WRITE) && !dat_done_q;
    assign rsp_vld       = (state_q == ST_RDRSP) && (s_resp != RSP_NULL);

    // Register the request fields so they stay stable until acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
            ord_q  <= ORD_WRAP;
            be_q   <= '0;
        end else if (req_fire) begin
            addr_q <= start_addr;
            len_q  <= cpu_req_len;
            ord_q  <= cpu_req_seq;
            be_q   <= cpu_req_be;
        end
    end

    // Drive the single request phase of the burst.
    always_comb begin
        if (state_q == ST_WRITE && req_pend_q) m_cmd = CMD_WRPOST;
        else if (state_q == ST_RDREQ)          m_cmd = CMD_READ;
        else                                   m_cmd = CMD_IDLE;
        m_addr   = addr_q;
        m_byteen = be_q;
        m_blen   = {{(BLW-1){1'b0}}, 1'b1} << len_q;
        m_bseq   = ord_q;
    end

    // Sequence the transaction: request, data or response, then idle.
    always_comb begin
        state_d    = state_q;
        req_pend_d = req_pend_q;
        dat_done_d = dat_done_q;
        case (state_q)
            ST_IDLE: begin
                if (req_fire) begin
                    state_d    = cpu_req_write ? ST_WRITE : ST_RDREQ;
                    req_pend_d = cpu_req_write;
                    dat_done_d = 1'b0;
                end
            end
            ST_WRITE: begin
                if (req_pend_q && s_cmd_accept) req_pend_d = 1'b0;
                if (wr_last)                    dat_done_d = 1'b1;
                if (!req_pend_d && dat_done_d)  state_d    = ST_IDLE;
            end
            ST_RDREQ: begin
                if (s_cmd_accept) state_d = ST_RDRSP;
            end
            ST_RDRSP: begin
                if (rsp_vld && s_resp_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Transaction state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_pend_q <= 1'b0;
            dat_done_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            req_pend_q <= req_pend_d;
            dat_done_q <= dat_done_d;
        end
    end

    bmp_beat_seq #(
        .AW(AW), .IDXW(IDXW), .LSB(LSB), .LCW(LCW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .load(req_fire), .ld_addr(start_addr), .ld_len(cpu_req_len),
        .ld_ord(cpu_req_seq), .adv(wr_beat || rsp_vld),
        .beat_addr(cpu_beat_addr), .beat_last(beat_last)
    );

    bmp_wr_lane #(
        .DW(DW), .BEW(BEW)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .active(wr_active), .last_beat(beat_last),
        .cpu_wdata_valid(cpu_wdata_valid), .cpu_wdata(cpu_wdata),
        .cpu_wbe(cpu_wbe), .s_data_accept(s_data_accept),
        .cpu_wdata_ready(cpu_wdata_ready), .m_dvalid(m_dvalid),
        .m_data(m_data), .m_dbyteen(m_dbyteen), .m_dlast(m_dlast),
        .beat_take(wr_beat), .last_take(wr_last)
    );

    bmp_err_sticky u_err (
        .clk(clk), .rst_n(rst_n),
        .set(s_error), .clr(cpu_err_clear), .flag(cpu_wr_err)
    );

    // Forward each read response beat in the cycle it arrives.
    always_comb begin
        cpu_rdata_valid = rsp_vld;
        cpu_rdata       = rsp_vld ? s_data : '0;
        cpu_rdata_err   = rsp_vld && (s_resp == RSP_ERR);
        cpu_rdata_last  = rsp_vld && s_resp_last;
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd != CMD_IDLE && !s_cmd_accept) |=>
        (m_cmd == $past(m_cmd) && $stable(m_addr) && $stable(m_blen)
         && $stable(m_bseq) && $stable(m_byteen)));
    assert_single_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd != CMD_IDLE && s_cmd_accept) |=> (m_cmd == CMD_IDLE));
    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |=> !cpu_req_ready);
    assert_read_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rdata_valid && cpu_rdata_last) |=> cpu_req_ready);
endmodule

// File: tb/sim_burst_master_port.sv
// Bench for the burst master port: directed corners plus seeded random
// bursts with random slave stalls, checked against bench-side models.
module sim_burst_master_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req_valid, cpu_req_ready, cpu_req_write, cpu_req_seq;
    logic [31:0] cpu_req_addr;
    logic [1:0]  cpu_req_len;
    logic [3:0]  cpu_req_be;
    logic        cpu_wdata_valid, cpu_wdata_ready;
    logic [31:0] cpu_wdata;
    logic [3:0]  cpu_wbe;
    logic [31:0] cpu_beat_addr;
    logic        cpu_rdata_valid, cpu_rdata_err, cpu_rdata_last;
    logic [31:0] cpu_rdata;
    logic        cpu_err_clear, cpu_wr_err;
    logic [1:0]  m_cmd;
    logic [31:0] m_addr;
    logic [3:0]  m_byteen;
    logic [3:0]  m_blen;
    logic        m_bseq, s_cmd_accept;
    logic        m_dvalid, m_dlast, s_data_accept;
    logic [31:0] m_data;
    logic [3:0]  m_dbyteen;
    logic [1:0]  s_resp;
    logic [31:0] s_data;
    logic        s_resp_last, s_error;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    burst_master_port u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected beat address from the order rules of R9 and R10.
    function automatic logic [31:0] beat_addr(input logic [31:0] a, input int lc,
                                              input logic ord, input int i);
        logic [2:0] w, m, s;
        w = a[4:2];
        m = 3'((1 << lc) - 1);
        s = ord ? (w ^ 3'(i)) : (w + 3'(i));
        return {a[31:5], (w & ~m) | (s & m), 2'b00};
    endfunction

    task automatic issue(input logic wr, input logic [31:0] a, input int lc,
                         input logic ord, input logic [3:0] be);
        @(posedge clk); #1;
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
        cpu_req_len = 2'(lc); cpu_req_seq = ord; cpu_req_be = be;
        @(negedge clk);
        chk("R8 ready before request", {31'b0, cpu_req_ready}, 32'd1);
        @(posedge clk); #1;
        cpu_req_valid = 1'b0;
    endtask

    // mode 0: no stalls, 1: random stalls, 2: request accepted after all data
    task automatic do_write(input logic [31:0] a, input int lc, input logic ord, input int mode);
        int n, beats;
        bit rdone, dv;
        logic [3:0] be;
        n = 1 << lc; beats = 0; rdone = 0; be = 4'($urandom);
        issue(1'b1, a, lc, ord, be);
        while (!(rdone && beats == n)) begin
            s_cmd_accept    = (mode == 0) ? 1'b1 : (mode == 1) ? 1'($urandom) : (beats == n);
            cpu_wdata_valid = (mode == 1) ? 1'($urandom) : 1'b1;
            s_data_accept   = (mode == 1) ? 1'($urandom) : 1'b1;
            cpu_wdata = $urandom; cpu_wbe = 4'($urandom);
            @(negedge clk);
            chk("R8 busy during write", {31'b0, cpu_req_ready}, 32'd0);
            if (!rdone) begin
                chk("R2 write cmd", {30'b0, m_cmd}, 32'd1);
                chk("R2 addr", m_addr, {a[31:2], 2'b00});
                chk("R2 byteen", {28'b0, m_byteen}, {28'b0, be});
                chk("R3 blen", {28'b0, m_blen}, 32'(n));
                chk("R2 bseq", {31'b0, m_bseq}, {31'b0, ord});
            end else begin
                chk("R2 single request", {30'b0, m_cmd}, 32'd0);
            end
            dv = (beats < n) && cpu_wdata_valid;
            chk("R4 dvalid", {31'b0, m_dvalid}, {31'b0, dv});
            chk("R4 wdata ready", {31'b0, cpu_wdata_ready}, {31'b0, (beats < n) && s_data_accept});
            if (dv) begin
                chk("R4 data", m_data, cpu_wdata);
                chk("R4 dbyteen", {28'b0, m_dbyteen}, {28'b0, cpu_wbe});
                chk("R4 dlast", {31'b0, m_dlast}, {31'b0, beats == n - 1});
                chk(ord ? "R10 xor beat addr" : "R9 wrap beat addr",
                    cpu_beat_addr, beat_addr(a, lc, ord, beats));
            end
            if (!rdone && s_cmd_accept) rdone = 1;
            if (dv && s_data_accept) beats++;
            @(posedge clk); #1;
        end
        s_cmd_accept = 1'b0; cpu_wdata_valid = 1'b0; s_data_accept = 1'b0;
        @(negedge clk);
        chk("R5 posted write done", {31'b0, cpu_req_ready}, 32'd1);
        chk("R2 idle after write", {30'b0, m_cmd}, 32'd0);
    endtask

    task automatic do_read(input logic [31:0] a, input int lc, input logic ord,
                           input int mode, input int errbeat);
        int n, beats;
        bit rdone, rv;
        n = 1 << lc; beats = 0; rdone = 0;
        issue(1'b0, a, lc, ord, 4'hF);
        while (!rdone) begin
            s_cmd_accept = (mode == 0) ? 1'b1 : 1'($urandom);
            s_resp = 2'($urandom); s_resp_last = 1'($urandom); s_data = $urandom;
            @(negedge clk);
            chk("R2 read cmd", {30'b0, m_cmd}, 32'd2);
            chk("R3 blen", {28'b0, m_blen}, 32'(n));
            chk("R12 noise during request", {31'b0, cpu_rdata_valid}, 32'd0);
            if (s_cmd_accept) rdone = 1;
            @(posedge clk); #1;
        end
        s_cmd_accept = 1'b0;
        while (beats < n) begin
            rv = (mode == 0) ? 1'b1 : ($urandom % 3 != 0);
            s_resp = rv ? ((beats == errbeat) ? 2'b11 : 2'b01) : 2'b00;
            s_resp_last = rv && (beats == n - 1);
            s_data = $urandom;
            @(negedge clk);
            chk("R2 idle during response", {30'b0, m_cmd}, 32'd0);
            chk("R6 rdata valid", {31'b0, cpu_rdata_valid}, {31'b0, rv});
            if (rv) begin
                chk("R6 rdata", cpu_rdata, s_data);
                chk("R6 err flag", {31'b0, cpu_rdata_err}, {31'b0, beats == errbeat});
                chk("R7 rdata last", {31'b0, cpu_rdata_last}, {31'b0, beats == n - 1});
                chk(ord ? "R10 xor beat addr" : "R9 wrap beat addr",
                    cpu_beat_addr, beat_addr(a, lc, ord, beats));
                beats++;
            end
            if (beats < n) chk("R8 busy during read", {31'b0, cpu_req_ready}, 32'd0);
            @(posedge clk); #1;
        end
        s_resp = 2'b00; s_resp_last = 1'b0;
        @(negedge clk);
        chk("R7 read done", {31'b0, cpu_req_ready}, 32'd1);
    endtask

    initial begin
        #(4 * 150000);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 1'b0;
        cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = 0; cpu_req_len = 0;
        cpu_req_seq = 0; cpu_req_be = 0; cpu_wdata_valid = 0; cpu_wdata = 0;
        cpu_wbe = 0; cpu_err_clear = 0; s_cmd_accept = 0; s_data_accept = 0;
        s_resp = 0; s_data = 0; s_resp_last = 0; s_error = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmd idle", {30'b0, m_cmd}, 32'd0);
        chk("R1 dvalid", {31'b0, m_dvalid}, 32'd0);
        chk("R1 rdata valid", {31'b0, cpu_rdata_valid}, 32'd0);
        chk("R1 ready", {31'b0, cpu_req_ready}, 32'd1);
        chk("R1 err flag", {31'b0, cpu_wr_err}, 32'd0);

        // R12: response noise while idle
        @(posedge clk); #1 s_resp = 2'b01; s_resp_last = 1'b1;
        @(negedge clk);
        chk("R12 idle noise", {31'b0, cpu_rdata_valid}, 32'd0);
        @(posedge clk); #1 s_resp = 2'b00; s_resp_last = 1'b0;

        // Directed corners
        do_write(32'h0000_1003, 0, 1'b0, 0);
        do_write(32'h0000_2014, 3, 1'b1, 0);
        do_write(32'h0000_300C, 2, 1'b0, 2);
        do_read (32'h0000_400C, 2, 1'b0, 0, 1);
        do_read (32'h0000_5018, 3, 1'b1, 0, 7);
        do_read (32'h0000_6004, 1, 1'b0, 1, -1);

        // R11: sticky posted-write error
        @(posedge clk); #1 s_error = 1'b1;
        @(negedge clk);
        chk("R11 not yet set", {31'b0, cpu_wr_err}, 32'd0);
        @(posedge clk); #1 s_error = 1'b0;
        @(negedge clk);
        chk("R11 set", {31'b0, cpu_wr_err}, 32'd1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 held", {31'b0, cpu_wr_err}, 32'd1);
        @(posedge clk); #1 cpu_err_clear = 1'b1;
        @(posedge clk); #1 cpu_err_clear = 1'b0;
        @(negedge clk);
        chk("R11 cleared", {31'b0, cpu_wr_err}, 32'd0);
        @(posedge clk); #1 s_error = 1'b1; cpu_err_clear = 1'b1;
        @(posedge clk); #1 s_error = 1'b0; cpu_err_clear = 1'b0;
        @(negedge clk);
        chk("R11 set wins", {31'b0, cpu_wr_err}, 32'd1);

        // Random bursts with random stalls
        for (int k = 0; k < 80; k++) begin
            int lc, eb;
            lc = int'($urandom % 4);
            eb = ($urandom % 4 == 0) ? int'($urandom % (1 << lc)) : -1;
            if ($urandom % 2) do_write($urandom, lc, 1'($urandom), ($urandom % 4 == 0) ? 2 : 1);
            else              do_read($urandom, lc, 1'($urandom), 1, eb);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule